// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter with Fixed or Rotating Order

This block picks one DMA channel out of four competing requesters each clock cycle and presents the choice as a registered one-hot grant. A request counts only while the channel's enable bit is set. The grant appears on the clock edge after the request wins, so the winning channel's transfer starts in the cycle after it became the top requester.

The priority order is a ring of the four channels. A two-bit head pointer names the channel that is currently on top. The head moves only when a transfer-done pulse arrives while rotation is switched on. The serviced channel then drops to the bottom of the ring, and the channel numbered one above it takes the top slot. When rotation is switched off, the head stays where the last rotation left it. Software can therefore reassign the top fixed priority: it enables rotation, lets one transfer complete on a single enabled channel, and then disables rotation again.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `grant` is all zeros. After reset the order from highest to lowest is channel 0, 1, 2, 3 (head = 0).
- R2: `grant` is registered. The winner chosen from the inputs seen before a rising clock edge appears on `grant` after that edge. Bit i of `grant` means channel i, and at most one bit is set.
- R3: A channel whose `chan_en` bit is 0 is never granted, whatever its `chan_req` bit is.
- R4: When no channel has both its request and enable bits set, `grant` becomes all zeros on the next edge and the order is unchanged.
- R5: The winner is the first qualified channel met when the ring is walked from the head upward (head, head+1, ... modulo 4).
- R6: A `xfer_done` pulse with `rotate_en` = 1 sets the head to `xfer_chan` + 1 modulo 4. For example, a done pulse on channel 1 from order 0,1,2,3 gives order 2,3,0,1.
- R7: A `xfer_done` pulse with `rotate_en` = 0 leaves the order unchanged.
- R8: When rotation is switched off, the order reached by rotation is kept and serves as the fixed order. The channel after the last serviced channel then has the highest fixed priority.
- R9: A done pulse on channel 3 with rotation on wraps the head to channel 0.
- R10: A grant decision made in the same cycle as a done pulse uses the order that held before the pulse. The new order affects decisions from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_req | input | 4 | Per-channel transfer request |
| chan_en | input | 4 | Per-channel DMA enable; qualifies the request |
| rotate_en | input | 1 | 1 = rotating priority, 0 = fixed priority |
| xfer_done | input | 1 | Single-cycle pulse: one word transfer finished |
| xfer_chan | input | 2 | Channel number the finished transfer belonged to |
| grant | output | 4 | Registered one-hot grant, all zeros when idle |

## Verification
The arbiter is driven with all channels requesting, with sparse requests that put a lower-priority channel ahead of the ring position, and with requests masked by cleared enables. These patterns separate a correct ring walk from a plain lowest-index pick and from an enable that is ignored. Done pulses are applied with rotation on, including on channel 3, and with rotation off. Each pulse is followed by a request pattern whose winner differs under the old and the new head, so a missed, early or wrongly wrapped head update shows up on `grant`. A final sequence selects a new top channel through a single-channel rotation and then returns to fixed mode. This confirms that the order is kept and that reset restores channel 0 as top.

// File: rtl/dma_prio_arb_pkg.sv
// Package: shared types for the DMA priority arbiter.
// Assumes the channel count is a power of two so that ring arithmetic
// wraps naturally in a head pointer of log2(channels) bits.
package dma_prio_arb_pkg;

    // Priority discipline selected by the mode input.
    typedef enum logic {
        ORDER_FIXED  = 1'b0,
        ORDER_ROTATE = 1'b1
    } order_mode_e;

endpackage

// File: rtl/dma_prio_qual.sv
// Module: dma_prio_qual
// Qualifies each channel request with that channel's enable bit.
// Assumes both vectors are sampled in the same cycle; purely combinational.
module dma_prio_qual #(
    parameter int N_CH = 4
) (
    input  logic [N_CH-1:0] req_i,
    input  logic [N_CH-1:0] en_i,
    output logic [N_CH-1:0] qual_o,
    output logic            any_o
);

    // One AND gate per channel: a disabled channel never competes.
    for (genvar g = 0; g < N_CH; g++) begin : g_qual
        assign qual_o[g] = req_i[g] & en_i[g];
    end

    // Flag that at least one channel is eligible.
    assign any_o = |qual_o;

endmodule

// File: rtl/dma_prio_pick.sv
// Module: dma_prio_pick
// Walks the channel ring starting at the head pointer and returns the
// first eligible channel as a one-hot vector.
// Assumes N_CH is a power of two (index arithmetic wraps in ID_W bits).
module dma_prio_pick #(
    parameter int N_CH = 4,
    localparam int ID_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] qual_i,
    input  logic [ID_W-1:0] head_i,
    output logic [N_CH-1:0] win_o
);

    logic [ID_W-1:0] idx;
    logic            found;

    // Ring search: the first qualified channel from the head upward wins.
    always_comb begin
        win_o = '0;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N_CH; k++) begin
            idx = head_i + ID_W'(k);
            if (!found && qual_i[idx]) begin
                win_o[idx] = 1'b1;
                found      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_prio_order.sv
// Module: dma_prio_order
// Holds the head pointer that defines the priority ring. On a done pulse
// in rotate mode the serviced channel drops to the bottom of the ring.
// Assumes done_i is a single-cycle pulse and chan_i is valid with it.
module dma_prio_order #(
    parameter int N_CH = 4,
    localparam int ID_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  dma_prio_arb_pkg::order_mode_e   mode_i,
    input  logic                            done_i,
    input  logic [ID_W-1:0]                 chan_i,
    output logic [ID_W-1:0]                 head_o
);

    logic [ID_W-1:0] head_q;

    // Head update: reset to channel 0; advance past the serviced channel only in rotate mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
        end else if (done_i && (mode_i == dma_prio_arb_pkg::ORDER_ROTATE)) begin
            head_q <= chan_i + ID_W'(1);
        end
    end

    assign head_o = head_q;

endmodule

// File: rtl/dma_prio_arb.sv
// Module: dma_prio_arb (top)
// Arbitrates N_CH DMA channel requests. Requests are qualified by enables,
// the winner is taken from a ring starting at a stored head pointer, and
// the one-hot grant is registered so the transfer starts the next cycle.
// Assumes a synchronous active-low reset and a power-of-two channel count.
module dma_prio_arb #(
    parameter int N_CH = 4,
    localparam int ID_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] chan_req,
    input  logic [N_CH-1:0] chan_en,
    input  logic            rotate_en,
    input  logic            xfer_done,
    input  logic [ID_W-1:0] xfer_chan,
    output logic [N_CH-1:0] grant
);

    import dma_prio_arb_pkg::*;

    logic [N_CH-1:0] qual;
    logic            qual_any;
    logic [N_CH-1:0] win;
    logic [ID_W-1:0] head_q;
    logic [N_CH-1:0] grant_q;
    order_mode_e     mode;

    // Map the mode pin onto the package enum.
    assign mode = rotate_en ? ORDER_ROTATE : ORDER_FIXED;

    dma_prio_qual #(.N_CH(N_CH)) u_qual (
        .req_i  (chan_req),
        .en_i   (chan_en),
        .qual_o (qual),
        .any_o  (qual_any)
    );

    dma_prio_pick #(.N_CH(N_CH)) u_pick (
        .qual_i (qual),
        .head_i (head_q),
        .win_o  (win)
    );

    dma_prio_order #(.N_CH(N_CH)) u_order (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode),
        .done_i (xfer_done),
        .chan_i (xfer_chan),
        .head_o (head_q)
    );

    // Grant register: clear in reset or when idle, else capture the ring winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
        end else if (!qual_any) begin
            grant_q <= '0;
        end else begin
            grant_q <= win;
        end
    end

    assign grant = grant_q;

endmodule

// File: rtl/dma_prio_arb_chk.sv
// Module: dma_prio_arb_chk
// Checker bound to dma_prio_arb; relates ports and the head pointer over time.
module dma_prio_arb_chk #(
    parameter int N_CH = 4,
    localparam int ID_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] chan_req,
    input logic [N_CH-1:0] chan_en,
    input logic            rotate_en,
    input logic            xfer_done,
    input logic [ID_W-1:0] xfer_chan,
    input logic [N_CH-1:0] grant,
    input logic [ID_W-1:0] head
);

    // R2: grant never names more than one channel.
    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3: a granted channel was both requesting and enabled one cycle earlier.
    p_grant_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((grant & ~$past(chan_req & chan_en)) == '0));

    // R4: no eligible channel means an empty grant on the next edge.
    p_idle_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((chan_req & chan_en) == '0) |=> (grant == '0));

    // R6: a done pulse in rotate mode puts the channel after the serviced one on top.
    p_head_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate_en && xfer_done) |=> (head == ID_W'($past(xfer_chan) + 1'b1)));

    // R7: without a rotating done pulse the order holds.
    p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rotate_en && xfer_done) |=> $stable(head));

endmodule

bind dma_prio_arb dma_prio_arb_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_req  (chan_req),
    .chan_en   (chan_en),
    .rotate_en (rotate_en),
    .xfer_done (xfer_done),
    .xfer_chan (xfer_chan),
    .grant     (grant),
    .head      (head_q)
);

// File: tb/tb_dma_prio_arb.sv
// Bench: vector table walked by one loop, then directed reset and wrap tests.
module tb_dma_prio_arb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] chan_req;
    logic [3:0] chan_en;
    logic       rotate_en;
    logic       xfer_done;
    logic [1:0] xfer_chan;
    logic [3:0] grant;

    int n_vec  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    dma_prio_arb dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_req  (chan_req),
        .chan_en   (chan_en),
        .rotate_en (rotate_en),
        .xfer_done (xfer_done),
        .xfer_chan (xfer_chan),
        .grant     (grant)
    );

    // Fields: {req[3:0], en[3:0], rotate, done, done_chan[1:0], expected grant[3:0]}
    // Head starts at 0; the comment beside each row gives the head in force for it.
    localparam int NV = 16;
    localparam logic [15:0] VEC [NV] = '{
        {4'b1111, 4'b1111, 1'b0, 1'b0, 2'd0, 4'b0001}, // 0  h0 R5 all request
        {4'b1110, 4'b1111, 1'b0, 1'b0, 2'd0, 4'b0010}, // 1  h0 R5
        {4'b1111, 4'b1110, 1'b0, 1'b0, 2'd0, 4'b0010}, // 2  h0 R3 ch0 disabled
        {4'b1000, 4'b0111, 1'b0, 1'b0, 2'd0, 4'b0000}, // 3  h0 R3 only disabled req
        {4'b0000, 4'b1111, 1'b0, 1'b0, 2'd0, 4'b0000}, // 4  h0 R4 idle
        {4'b1111, 4'b1111, 1'b1, 1'b1, 2'd1, 4'b0001}, // 5  h0 R10 done ch1 -> h2
        {4'b1111, 4'b1111, 1'b1, 1'b0, 2'd0, 4'b0100}, // 6  h2 R6 order 2,3,0,1
        {4'b0011, 4'b1111, 1'b1, 1'b0, 2'd0, 4'b0001}, // 7  h2 R6
        {4'b1010, 4'b1111, 1'b1, 1'b1, 2'd3, 4'b1000}, // 8  h2 R9 done ch3 -> h0
        {4'b1010, 4'b1111, 1'b0, 1'b0, 2'd0, 4'b0010}, // 9  h0 R9 wrapped
        {4'b1100, 4'b1111, 1'b0, 1'b1, 2'd2, 4'b0100}, // 10 h0 R7 done, no rotate
        {4'b1100, 4'b1111, 1'b0, 1'b0, 2'd0, 4'b0100}, // 11 h0 R7 order unchanged
        {4'b0001, 4'b0001, 1'b1, 1'b1, 2'd0, 4'b0001}, // 12 h0 R8 single-channel rotation -> h1
        {4'b1111, 4'b1111, 1'b0, 1'b0, 2'd0, 4'b0010}, // 13 h1 R8 fixed order kept
        {4'b0001, 4'b1111, 1'b0, 1'b0, 2'd0, 4'b0001}, // 14 h1 R8
        {4'b1101, 4'b1111, 1'b0, 1'b0, 2'd0, 4'b0100}  // 15 h1 R8 order 1,2,3,0
    };

    // Compare one observed grant with its expected value.
    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one input set at the falling edge.
    task automatic drive(input logic [3:0] r, input logic [3:0] e,
                         input logic rot, input logic dn, input logic [1:0] ch);
        chan_req  = r;
        chan_en   = e;
        rotate_en = rot;
        xfer_done = dn;
        xfer_chan = ch;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(4'b1111, 4'b1111, 1'b0, 1'b0, 2'd0);
        repeat (3) @(negedge clk);
        check("R1 grant in reset", grant, 4'b0000);
        rst_n = 1'b1;
        drive(4'b0000, 4'b1111, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        check("R1 first cycle after reset", grant, 4'b0000);

        // Table walk: drive at negedge, sample after the next rising edge.
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][15:12], VEC[i][11:8], VEC[i][7], VEC[i][6], VEC[i][5:4]);
            @(negedge clk);
            check($sformatf("R2 vector %0d", i), grant, VEC[i][3:0]);
        end

        // R2: grant does not change before the clock edge.
        drive(4'b1000, 4'b1111, 1'b0, 1'b0, 2'd0);
        #2;
        check("R2 no early grant", grant, 4'b0100);
        @(negedge clk);
        check("R2 registered grant", grant, 4'b1000);

        // R1: reset restores order 0,1,2,3 after a rotation moved the head to 3.
        drive(4'b0000, 4'b1111, 1'b1, 1'b1, 2'd2);
        @(negedge clk);
        drive(4'b1111, 4'b1111, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        check("R1 pre-reset head 3", grant, 4'b1000);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 order restored", grant, 4'b0001);

        // R4: idle cycles keep the order.
        drive(4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0);
        repeat (3) @(negedge clk);
        check("R4 idle grant", grant, 4'b0000);
        drive(4'b1110, 4'b1111, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        check("R4 order held after idle", grant, 4'b0010);

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule